// File: doc/BRIEF.md
# Snooping MESI Cache Line Controller

This block manages coherence for a small direct-mapped private cache that sits on a shared snooping bus. Every line holds a tag, a multi-word data block and one of four coherence states: Invalid, Shared (clean, other copies may exist), Exclusive (clean, this is the only copy) and Modified (dirty, this is the only copy). A local requester issues loads and stores; misses and ownership upgrades go out as bus transactions, and transactions seen from other caches are snooped and answered.

The requester holds its request steady until the done pulse. A request that needs the bus emits a one-cycle bus request (0 = shared read, 1 = read for ownership) and waits for a bus response that carries the full line and a flag telling whether another cache holds it. Snooped transactions are processed in the cycle they are presented; dirty data leaves through a write-back port before a line is given up. The Exclusive state lets a store to a sole-held line complete locally with no bus traffic.

With default parameters an address is 8 bits: bit 0 selects the 16-bit word in a two-word line, bits [2:1] select one of four lines and bits [7:3] are the tag. Line addresses on the bus, snoop and write-back ports are address bits [7:1]; word 0 of a line occupies data bits [15:0].

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is Invalid and req_done, bus_req_valid, wb_valid and snoop_shared are low; a snoop then finds no line.
- R2: A load that misses emits a bus request with op 0 one cycle after acceptance; after the response the line becomes Exclusive if the response shared flag is 0, otherwise Shared, and req_done pulses one cycle after the response with the requested word.
- R3: A store to an Exclusive line completes one cycle after acceptance with no bus request, and the line becomes Modified.
- R4: A store to a Modified line completes one cycle after acceptance with no bus request and the line stays Modified.
- R5: A store to a Shared or absent line emits a bus request with op 1; the fetched line is merged with the stored word, the line becomes Modified and req_done pulses one cycle after the response.
- R6: A load that hits a valid line completes one cycle after acceptance with the stored word, no bus request and no state change.
- R7: A snooped shared read (op 0) to a Modified line writes the whole line back one cycle later and leaves the line Shared.
- R8: A snooped shared read to an Exclusive or Shared line leaves it Shared with no write-back.
- R9: A snooped read for ownership (op 1) to a valid line makes it Invalid; a Modified line is written back one cycle later, a clean one is not.
- R10: snoop_shared is high one cycle after a snooped shared read hits a valid line, and low after a read for ownership or a snoop that misses.
- R11: A miss whose slot holds a Modified line of another tag writes that victim back in the cycle the bus request appears; a Shared or Exclusive victim is dropped with no write-back.
- R12: A snoop to a line not held has no effect: no write-back, no shared response, and later accesses see the unchanged line.
- R13: No request is accepted in a cycle with snoop_valid high, and after any snoop hit the line is neither Modified nor Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present, held until req_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Requested word after the operation, valid with req_done |
| bus_req_valid | output | 1 | One-cycle bus request pulse |
| bus_req_op | output | 1 | 0 = shared read, 1 = read for ownership |
| bus_req_addr | output | AW-log2(WORDS) | Line address of the bus request |
| bus_resp_valid | input | 1 | Bus response with line data |
| bus_resp_shared | input | 1 | Another cache holds the line |
| bus_resp_data | input | DW*WORDS | Line data of the response |
| snoop_valid | input | 1 | Transaction from another cache |
| snoop_op | input | 1 | 0 = shared read, 1 = read for ownership |
| snoop_addr | input | AW-log2(WORDS) | Line address of the snooped transaction |
| snoop_shared | output | 1 | This cache holds the snooped line (shared read only) |
| wb_valid | output | 1 | Write-back pulse toward memory |
| wb_addr | output | AW-log2(WORDS) | Line address of the write-back |
| wb_data | output | DW*WORDS | Line data of the write-back |

## Verification
Hits, quiet stores, bus requests, eviction write-backs, snoop write-backs and the shared response are all due exactly one cycle after the accepting or snooping clock edge, and a bus-served request completes one cycle after the response edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each result is read in the very cycle it is due, and it also checks that the bus request pulse is gone a cycle later. A bench model of tags, states and line data predicts each value; coherence state that has no port of its own is read out through later snoops and stores.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic {
    F_IDLE = 1'b0,
    F_WAIT = 1'b1
  } fsm_t;

  localparam logic OP_RD  = 1'b0;
  localparam logic OP_RDX = 1'b1;
endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array import coh_pkg::*; #(
  parameter int NLINES = 4,
  parameter int TW     = 5,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [IW-1:0]                ra_idx,
  output logic [TW-1:0]                ra_tag,
  output mesi_t                        ra_state,
  input  logic [IW-1:0]                sa_idx,
  output logic [TW-1:0]                sa_tag,
  output mesi_t                        sa_state,
  input  logic                         upd_en,
  input  logic [IW-1:0]                upd_idx,
  input  logic [TW-1:0]                upd_tag,
  input  mesi_t                        upd_state,
  input  logic                         sn_en,
  input  logic [IW-1:0]                sn_idx,
  input  mesi_t                        sn_state,
  output logic [NLINES-1:0][1:0]       states_o
);
  logic [NLINES-1:0][TW-1:0] tags;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    mesi_t           st_q;
    logic [TW-1:0]   tg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= ST_I;
        tg_q <= '0;
      end else if (upd_en && upd_idx == IW'(i)) begin
        st_q <= upd_state;
        tg_q <= upd_tag;
      end else if (sn_en && sn_idx == IW'(i)) begin
        st_q <= sn_state;
      end
    end
    assign states_o[i] = st_q;
    assign tags[i]     = tg_q;
  end

  assign ra_tag   = tags[ra_idx];
  assign ra_state = mesi_t'(states_o[ra_idx]);
  assign sa_tag   = tags[sa_idx];
  assign sa_state = mesi_t'(states_o[sa_idx]);
endmodule

// File: rtl/coh_data_array.sv
module coh_data_array #(
  parameter int NLINES = 4,
  parameter int LW     = 32,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [LW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [LW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [LW-1:0] rdata_b
);
  logic [LW-1:0] mem [NLINES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/coh_snoop_eval.sv
module coh_snoop_eval import coh_pkg::*; (
  input  logic  valid,
  input  logic  op,
  input  logic  tag_match,
  input  mesi_t cur,
  output logic  hit,
  output mesi_t nxt,
  output logic  wb,
  output logic  shared
);
  always_comb begin
    hit    = valid && tag_match && (cur != ST_I);
    nxt    = (op == OP_RDX) ? ST_I : ST_S;
    wb     = hit && (cur == ST_M);
    shared = hit && (op == OP_RD);
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl import coh_pkg::*; #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int WORDS  = 2,
  parameter int NLINES = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [AW-1:0]                   req_addr,
  input  logic [DW-1:0]                   req_wdata,
  output logic                            req_done,
  output logic [DW-1:0]                   req_rdata,
  output logic                            bus_req_valid,
  output logic                            bus_req_op,
  output logic [AW-$clog2(WORDS)-1:0]     bus_req_addr,
  input  logic                            bus_resp_valid,
  input  logic                            bus_resp_shared,
  input  logic [DW*WORDS-1:0]             bus_resp_data,
  input  logic                            snoop_valid,
  input  logic                            snoop_op,
  input  logic [AW-$clog2(WORDS)-1:0]     snoop_addr,
  output logic                            snoop_shared,
  output logic                            wb_valid,
  output logic [AW-$clog2(WORDS)-1:0]     wb_addr,
  output logic [DW*WORDS-1:0]             wb_data
);
  localparam int OW  = $clog2(WORDS);
  localparam int IW  = $clog2(NLINES);
  localparam int TW  = AW - OW - IW;
  localparam int LW  = DW * WORDS;
  localparam int LAW = AW - OW;

  // request address fields
  logic [OW-1:0] r_off;
  logic [IW-1:0] r_idx;
  logic [TW-1:0] r_tag;
  logic [IW-1:0] s_idx;
  logic [TW-1:0] s_tag;
  assign r_off = req_addr[OW-1:0];
  assign r_idx = req_addr[OW +: IW];
  assign r_tag = req_addr[AW-1 -: TW];
  assign s_idx = snoop_addr[IW-1:0];
  assign s_tag = snoop_addr[LAW-1 -: TW];

  // pending request captured at acceptance
  fsm_t          fsm_q;
  logic          p_write;
  logic [OW-1:0] p_off;
  logic [IW-1:0] p_idx;
  logic [TW-1:0] p_tag;
  logic [DW-1:0] p_wdata;

  // array interfaces
  logic [TW-1:0] ra_tag, sa_tag;
  mesi_t         ra_state, sa_state;
  logic          upd_en;
  logic [IW-1:0] upd_idx;
  logic [TW-1:0] upd_tag;
  mesi_t         upd_state;
  logic [NLINES-1:0][1:0] line_states;
  logic          d_we;
  logic [IW-1:0] d_widx;
  logic [LW-1:0] d_wdata, rd_a, rd_b;

  // snoop decision
  logic  sn_hit, sn_wb, sn_shared;
  mesi_t sn_nxt;

  // request decode
  logic          acc, req_hit, hit_rd, hit_wq, need_bus, miss_acc, evict_wb, fill, e_write;
  logic [LW-1:0] m_hit, m_fill;

  coh_tag_array #(.NLINES(NLINES), .TW(TW)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .ra_idx   (r_idx),
    .ra_tag   (ra_tag),
    .ra_state (ra_state),
    .sa_idx   (s_idx),
    .sa_tag   (sa_tag),
    .sa_state (sa_state),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_tag  (upd_tag),
    .upd_state(upd_state),
    .sn_en    (sn_hit),
    .sn_idx   (s_idx),
    .sn_state (sn_nxt),
    .states_o (line_states)
  );

  coh_data_array #(.NLINES(NLINES), .LW(LW)) u_data (
    .clk    (clk),
    .we     (d_we),
    .widx   (d_widx),
    .wdata  (d_wdata),
    .ridx_a (r_idx),
    .rdata_a(rd_a),
    .ridx_b (s_idx),
    .rdata_b(rd_b)
  );

  coh_snoop_eval u_snoop (
    .valid    (snoop_valid),
    .op       (snoop_op),
    .tag_match(sa_tag == s_tag),
    .cur      (sa_state),
    .hit      (sn_hit),
    .nxt      (sn_nxt),
    .wb       (sn_wb),
    .shared   (sn_shared)
  );

  always_comb begin
    acc      = (fsm_q == F_IDLE) && req_valid && !snoop_valid;
    req_hit  = (ra_state != ST_I) && (ra_tag == r_tag);
    hit_rd   = acc && !req_write && req_hit;
    hit_wq   = acc && req_write && req_hit && (ra_state == ST_E || ra_state == ST_M);
    e_write  = hit_wq && (ra_state == ST_E);
    need_bus = acc && !hit_rd && !hit_wq;
    miss_acc = need_bus && !req_hit;
    evict_wb = miss_acc && (ra_state == ST_M);
    fill     = (fsm_q == F_WAIT) && bus_resp_valid;
  end

  // word merges for a quiet store and for a fill
  always_comb begin
    m_hit  = rd_a;
    m_hit[int'(r_off)*DW +: DW] = req_wdata;
    m_fill = bus_resp_data;
    if (p_write) m_fill[int'(p_off)*DW +: DW] = p_wdata;
  end

  always_comb begin
    upd_en    = hit_wq || miss_acc || fill;
    upd_idx   = fill ? p_idx : r_idx;
    upd_tag   = fill ? p_tag : r_tag;
    if (fill)        upd_state = p_write ? ST_M : (bus_resp_shared ? ST_S : ST_E);
    else if (hit_wq) upd_state = ST_M;
    else             upd_state = ST_I;
    d_we    = hit_wq || fill;
    d_widx  = fill ? p_idx : r_idx;
    d_wdata = fill ? m_fill : m_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q   <= F_IDLE;
      p_write <= 1'b0;
      p_off   <= '0;
      p_idx   <= '0;
      p_tag   <= '0;
      p_wdata <= '0;
    end else begin
      if (need_bus) begin
        fsm_q   <= F_WAIT;
        p_write <= req_write;
        p_off   <= r_off;
        p_idx   <= r_idx;
        p_tag   <= r_tag;
        p_wdata <= req_wdata;
      end else if (fill) begin
        fsm_q <= F_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_done      <= 1'b0;
      req_rdata     <= '0;
      bus_req_valid <= 1'b0;
      bus_req_op    <= 1'b0;
      bus_req_addr  <= '0;
      snoop_shared  <= 1'b0;
      wb_valid      <= 1'b0;
      wb_addr       <= '0;
      wb_data       <= '0;
    end else begin
      req_done      <= hit_rd || hit_wq || fill;
      if (hit_rd)      req_rdata <= rd_a[int'(r_off)*DW +: DW];
      else if (hit_wq) req_rdata <= req_wdata;
      else if (fill)   req_rdata <= m_fill[int'(p_off)*DW +: DW];
      bus_req_valid <= need_bus;
      if (need_bus) begin
        bus_req_op   <= req_write;
        bus_req_addr <= {r_tag, r_idx};
      end
      snoop_shared  <= sn_shared;
      wb_valid      <= sn_wb || evict_wb;
      if (sn_wb) begin
        wb_addr <= snoop_addr;
        wb_data <= rd_b;
      end else if (evict_wb) begin
        wb_addr <= {ra_tag, r_idx};
        wb_data <= rd_a;
      end
    end
  end
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk import coh_pkg::*; #(
  parameter int NLINES = 4,
  localparam int IW    = $clog2(NLINES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   snoop_valid,
  input logic                   snoop_op,
  input logic                   sn_hit,
  input logic [1:0]             sn_state,
  input logic [IW-1:0]          sn_idx,
  input logic [NLINES-1:0][1:0] states,
  input logic                   wb_valid,
  input logic                   bus_req_valid,
  input logic                   e_write,
  input logic [IW-1:0]          req_idx,
  input logic                   fill
);
  // R3: store to an Exclusive line upgrades quietly
  a_r3_quiet_upgrade: assert property (@(posedge clk) disable iff (rst)
    e_write |=> !bus_req_valid && states[$past(req_idx)] == 2'(ST_M));

  // R7: dirty line written back on a snooped shared read
  a_r7_dirty_wb: assert property (@(posedge clk) disable iff (rst)
    snoop_valid && snoop_op == OP_RD && sn_hit && sn_state == 2'(ST_M) |=> wb_valid);

  // R8: clean lines are never written back on a snoop
  a_r8_clean_no_wb: assert property (@(posedge clk) disable iff (rst)
    snoop_valid && sn_hit && sn_state != 2'(ST_M) |=> !wb_valid);

  // R9: read for ownership leaves the line Invalid
  a_r9_rdx_invalid: assert property (@(posedge clk) disable iff (rst)
    snoop_valid && snoop_op == OP_RDX && sn_hit && !fill |=> states[$past(sn_idx)] == 2'(ST_I));

  // R13: after a snoop hit this cache holds no writable copy
  a_r13_swmr_local: assert property (@(posedge clk) disable iff (rst)
    snoop_valid && sn_hit && !fill |=>
      states[$past(sn_idx)] != 2'(ST_M) && states[$past(sn_idx)] != 2'(ST_E));
endmodule

bind coh_ctrl coh_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .snoop_valid  (snoop_valid),
  .snoop_op     (snoop_op),
  .sn_hit       (sn_hit),
  .sn_state     (sa_state),
  .sn_idx       (s_idx),
  .states       (line_states),
  .wb_valid     (wb_valid),
  .bus_req_valid(bus_req_valid),
  .e_write      (e_write),
  .req_idx      (r_idx),
  .fill         (fill)
);

// File: tb/test_coh_ctrl.sv
module test_coh_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        req_done;
  logic [15:0] req_rdata;
  logic        bus_req_valid, bus_req_op;
  logic [6:0]  bus_req_addr;
  logic        bus_resp_valid = 0, bus_resp_shared = 0;
  logic [31:0] bus_resp_data = 0;
  logic        snoop_valid = 0, snoop_op = 0;
  logic [6:0]  snoop_addr = 0;
  logic        snoop_shared, wb_valid;
  logic [6:0]  wb_addr;
  logic [31:0] wb_data;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  coh_ctrl i_coh_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
    .bus_resp_valid(bus_resp_valid), .bus_resp_shared(bus_resp_shared), .bus_resp_data(bus_resp_data),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
    .snoop_shared(snoop_shared), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // reference model: 0=I 1=S 2=E 3=M
  int          m_st [4];
  logic [4:0]  m_tg [4];
  logic [31:0] m_dat [4];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] put(input logic [31:0] l, input logic o, input logic [15:0] w);
    logic [31:0] r = l;
    if (o) r[31:16] = w; else r[15:0] = w;
    return r;
  endfunction

  function automatic logic [15:0] word(input logic [31:0] l, input logic o);
    return o ? l[31:16] : l[15:0];
  endfunction

  task automatic do_req(input logic w, input logic [7:0] a, input logic [15:0] d,
                        input logic sh, input logic [31:0] rd, input string tag);
    int   idx = int'(a[2:1]);
    logic hit = (m_st[idx] != 0) && (m_tg[idx] == a[7:3]);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    if (hit && (!w || m_st[idx] >= 2)) begin
      chk(req_done == 1, {tag, " done after hit"}, 32'(req_done), 1);
      chk(bus_req_valid == 0, {tag, " no bus on hit"}, 32'(bus_req_valid), 0);
      if (w) m_dat[idx] = put(m_dat[idx], a[0], d);
      if (w) m_st[idx] = 3;
      chk(req_rdata == word(m_dat[idx], a[0]), {tag, " hit data"}, 32'(req_rdata), 32'(word(m_dat[idx], a[0])));
      req_valid = 0;
    end else begin
      logic vic = !hit && m_st[idx] == 3;
      chk(req_done == 0, {tag, " not done before bus"}, 32'(req_done), 0);
      chk(bus_req_valid == 1 && bus_req_op == w && bus_req_addr == a[7:1], {tag, " bus request"},
          {23'd0, bus_req_valid, bus_req_op, bus_req_addr}, {23'd0, 1'b1, w, a[7:1]});
      chk(wb_valid == vic, {tag, " victim write-back (R11)"}, 32'(wb_valid), 32'(vic));
      if (vic) chk(wb_addr == {m_tg[idx], a[2:1]} && wb_data == m_dat[idx], {tag, " victim data (R11)"},
                   wb_data, m_dat[idx]);
      @(negedge clk);
      chk(bus_req_valid == 0, {tag, " bus request is a pulse"}, 32'(bus_req_valid), 0);
      bus_resp_valid = 1; bus_resp_shared = sh; bus_resp_data = rd;
      @(posedge clk); @(negedge clk);
      bus_resp_valid = 0; req_valid = 0;
      m_tg[idx]  = a[7:3];
      m_dat[idx] = w ? put(rd, a[0], d) : rd;
      m_st[idx]  = w ? 3 : (sh ? 1 : 2);
      chk(req_done == 1, {tag, " done after response"}, 32'(req_done), 1);
      chk(req_rdata == word(m_dat[idx], a[0]), {tag, " fill data"}, 32'(req_rdata), 32'(word(m_dat[idx], a[0])));
    end
  endtask

  task automatic do_snoop(input logic op, input logic [6:0] la, input string tag);
    int   idx = int'(la[1:0]);
    logic hit = (m_st[idx] != 0) && (m_tg[idx] == la[6:2]);
    logic ewb = hit && m_st[idx] == 3;
    @(negedge clk);
    snoop_valid = 1; snoop_op = op; snoop_addr = la;
    @(posedge clk); @(negedge clk);
    snoop_valid = 0;
    chk(snoop_shared == (hit && !op), {tag, " shared response (R10)"}, 32'(snoop_shared), 32'(hit && !op));
    chk(wb_valid == ewb, {tag, " snoop write-back"}, 32'(wb_valid), 32'(ewb));
    if (ewb) chk(wb_addr == la && wb_data == m_dat[idx], {tag, " snoop write-back data"}, wb_data, m_dat[idx]);
    if (hit) m_st[idx] = op ? 0 : 1;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dat[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1
    chk(!req_done && !bus_req_valid && !wb_valid && !snoop_shared, "R1 outputs idle after reset",
        {28'd0, req_done, bus_req_valid, wb_valid, snoop_shared}, 0);
    do_snoop(1, 7'h00, "R1 empty cache");

    do_req(0, 8'h00, 0, 0, 32'hBEEF_1234, "R2 miss to E");
    do_req(0, 8'h01, 0, 0, 0, "R6 read hit");
    do_req(1, 8'h00, 16'hA5A5, 0, 0, "R3 store on E");
    do_req(1, 8'h01, 16'h0F0F, 0, 0, "R4 store on M");
    do_snoop(0, 7'h00, "R7 shared read on M");
    do_snoop(0, 7'h00, "R8 shared read on S");
    do_req(1, 8'h01, 16'h7777, 0, 32'h1111_2222, "R5 store on S");
    do_snoop(1, 7'h00, "R9 ownership on M");
    do_req(0, 8'h02, 0, 1, 32'h3333_4444, "R2 miss to S");
    do_snoop(1, 7'h01, "R9 ownership on S");
    do_req(1, 8'h03, 16'h5555, 0, 32'h6666_8888, "R5 store miss");
    do_req(0, 8'h04, 0, 0, 32'h9999_AAAA, "R2 miss to E idx2");
    do_snoop(0, 7'h02, "R8 shared read on E");
    do_req(1, 8'h06, 16'hCAFE, 0, 32'h0, "R11 setup");
    do_req(0, 8'h0E, 0, 0, 32'hD00D_F00D, "R11 dirty victim");
    do_req(0, 8'h16, 0, 0, 32'h1357_2468, "R11 clean victim");
    do_snoop(0, 7'h7F, "R12 foreign line");
    do_snoop(1, 7'h47, "R12 foreign line");
    do_req(0, 8'h17, 0, 0, 0, "R12 line unchanged");

    // R13: request held off while a snoop is present
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h04;
    snoop_valid = 1; snoop_op = 0; snoop_addr = 7'h7E;
    @(posedge clk); @(negedge clk);
    chk(req_done == 0 && bus_req_valid == 0, "R13 no acceptance during snoop",
        {30'd0, req_done, bus_req_valid}, 0);
    snoop_valid = 0;
    @(posedge clk); @(negedge clk);
    chk(req_done == 1 && req_rdata == word(m_dat[2], 0), "R13 accepted after snoop",
        {15'd0, req_done, req_rdata}, {16'd1, word(m_dat[2], 0)});
    req_valid = 0;
    do_snoop(1, 7'h02, "R13 hit drops line");
    do_req(1, 8'h04, 16'h4242, 0, 32'hABCD_0001, "R13 store needs ownership again");

    // constrained random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom % 4);
      logic [7:0] a = 8'($urandom % 32);
      if (k < 2)
        do_req(k[0], a, 16'($urandom), 1'($urandom), $urandom, "R2/R5 random request");
      else
        do_snoop(k[0], a[7:1], "R7/R9 random snoop");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule